// File: doc/BRIEF.md
# Serial Port Transmit and Receive Queue Pair

This block sits between a small register bus and the serial shift logic of a UART. Software writes bytes into a transmit window and the shifter drains them with a valid/ready handshake. The receiver pushes each finished character, with its parity-error and framing-error flags, into a receive queue, and software pops it by reading a receive window. A read-only index word reports how many entries each queue holds.

A control word enables both queues, holds a receive-timeout length in character times, and has one self-clearing reset bit for each queue. The block raises level events for empty, almost-empty, almost-full and full, one-cycle pulses for transmit overflow, transmit underrun and receive overrun, and a receive-timeout level. Serial framing and interrupt masking belong to other blocks.

Bus map (2-bit address): 0 transmit window (write pushes), 1 receive window (read pops), 2 control (read/write), 3 index (read only).

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both counts are 0, the control word reads 0, tx_valid_o is 0, tx_empty_o and tx_aempty_o are 1, and rx_full_o, rx_afull_o, rx_timeout_o and all pulses are 0.
- R2: With the queues enabled, a bus write to address 0 stores bus_wdata_i[7:0]; tx_valid_o is high while the transmit queue holds data, tx_data_o shows the oldest byte, and one byte leaves on each clock edge where tx_valid_o and tx_ready_i are both high.
- R3: A receive entry holds data in bits 7:0, the parity-error flag in bit 8 and the framing-error flag in bit 9; a read of address 1 returns the oldest entry zero-extended and pops it, and a read of an empty receive queue returns 0 and changes nothing.
- R4: The transmit queue holds 16 bytes; a write to a full queue is dropped, the stored bytes are kept, and tx_overflow_o is high for the one cycle after that write.
- R5: The receive queue holds 16 entries; a character arriving at a full queue is dropped, the stored entries are kept unchanged, and rx_overrun_o is high for the one cycle after that arrival.
- R6: Control bit 0 enables the queues; while it is 0, bus writes to address 0 and arriving characters are ignored, tx_valid_o is 0, and reads of address 1 return 0 without popping.
- R7: Writing 1 to control bit 2 (transmit) or bit 3 (receive) makes that bit read back 1 for one cycle; at the next edge the chosen queue is emptied, the bit reads 0, and the other queue is untouched.
- R8: The index word (address 3) has the transmit count (0 to 16) in bits 4:0 and the receive count (0 to 16) in bits 12:8; tx_empty_o is count 0, tx_aempty_o is transmit count 4 or fewer, rx_afull_o is receive count 12 or more, rx_full_o is receive count 16.
- R9: tx_underrun_o is high for the one cycle after an edge where the queues are enabled, tx_ready_i is high and the transmit queue is empty.
- R10: Control bits 7:4 hold N; with N not 0 and the receive queue not empty, rx_timeout_o rises once N char_tick_i pulses have been seen since the last character arrived, and falls on the next arrival or when the queue empties; N = 0 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Shifter takes a byte |
| rx_char_i | input | 10 | Received character with error flags |
| rx_valid_i | input | 1 | Character arrives this cycle |
| char_tick_i | input | 1 | One pulse per character time |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_aempty_o | output | 1 | Transmit queue almost empty |
| rx_afull_o | output | 1 | Receive queue almost full |
| rx_full_o | output | 1 | Receive queue full |
| tx_overflow_o | output | 1 | Write to full transmit queue, pulse |
| tx_underrun_o | output | 1 | Shifter asked of empty queue, pulse |
| rx_overrun_o | output | 1 | Character lost at full receive queue, pulse |
| rx_timeout_o | output | 1 | Receive data idle too long |

## Verification
A corrupted pointer or count shows at once in the index word and within one pop on tx_data_o or the receive window, because both queues are filled with distinct patterns and drained in full. A lost flag bit in a receive entry appears on the first read of that entry. A wrong full or empty decision shows in the cycle after the boundary write or arrival as a missing or spurious overflow, overrun or underrun pulse, and the stored contents read back after an overrun expose any overwrite. A stale flush bit shows on the control readback two cycles after the write.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    ADDR_TX   = 2'd0,
    ADDR_RX   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_IDX  = 2'd3
  } reg_addr_e;

  localparam int unsigned BUS_W      = 16;
  localparam int unsigned RX_IDX_LSB = 8;
  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_TXRST = 2;
  localparam int unsigned CTRL_RXRST = 3;
  localparam int unsigned CTRL_TOUT  = 4;
endpackage

// File: rtl/uart_fifo_queue.sv
module uart_fifo_queue #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/uart_fifo_rx_timer.sv
module uart_fifo_rx_timer #(
  parameter int unsigned TOUT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arrive_i,
  input  logic              empty_i,
  input  logic              tick_i,
  input  logic [TOUT_W-1:0] limit_i,
  output logic              timeout_o
);
  logic [TOUT_W-1:0] idle_q;

  // idle character times since last arrival, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idle_q <= '0;
    else if (arrive_i || empty_i)      idle_q <= '0;
    else if (tick_i && (idle_q != '1)) idle_q <= idle_q + 1'b1;
  end

  assign timeout_o = !empty_i && (limit_i != '0) && (idle_q >= limit_i);
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TX_W       = 8,
  parameter int unsigned RX_W       = 10,
  parameter int unsigned AEMPTY_LVL = 4,
  parameter int unsigned AFULL_LVL  = 12,
  parameter int unsigned TOUT_W     = 4,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic [TX_W-1:0]  tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [RX_W-1:0]  rx_char_i,
  input  logic             rx_valid_i,
  input  logic             char_tick_i,
  output logic             tx_empty_o,
  output logic             tx_aempty_o,
  output logic             rx_afull_o,
  output logic             rx_full_o,
  output logic             tx_overflow_o,
  output logic             tx_underrun_o,
  output logic             rx_overrun_o,
  output logic             rx_timeout_o
);
  logic              en_q, tx_flush_q, rx_flush_q;
  logic [TOUT_W-1:0] tout_q;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [RX_W-1:0]   rx_head;
  logic              tx_full, rx_empty;
  logic              wr_tx, wr_ctrl, rd_rx, tx_push, tx_pop, rx_push, rx_pop;
  logic              tx_ovf_q, tx_udr_q, rx_ovr_q;
  logic              unused_bits;

  assign wr_tx   = bus_req_i && bus_we_i  && (reg_addr_e'(bus_addr_i) == ADDR_TX);
  assign wr_ctrl = bus_req_i && bus_we_i  && (reg_addr_e'(bus_addr_i) == ADDR_CTRL);
  assign rd_rx   = bus_req_i && !bus_we_i && (reg_addr_e'(bus_addr_i) == ADDR_RX);
  assign tx_push = en_q && wr_tx;
  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rx_push = en_q && rx_valid_i;
  assign rx_pop  = en_q && rd_rx;
  assign unused_bits = ^{bus_wdata_i[BUS_W-1:CTRL_TOUT+TOUT_W], bus_wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
      tout_q     <= '0;
    end else if (wr_ctrl) begin
      en_q       <= bus_wdata_i[CTRL_EN];
      tx_flush_q <= bus_wdata_i[CTRL_TXRST];
      rx_flush_q <= bus_wdata_i[CTRL_RXRST];
      tout_q     <= bus_wdata_i[CTRL_TOUT +: TOUT_W];
    end else begin
      // flush completes in the edge that sees the bit
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end
  end

  uart_fifo_queue #(.WIDTH(TX_W), .DEPTH(DEPTH)) tx_q_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush_q),
    .push_i  (tx_push),
    .data_i  (bus_wdata_i[TX_W-1:0]),
    .pop_i   (tx_pop),
    .data_o  (tx_data_o),
    .cnt_o   (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty_o)
  );

  uart_fifo_queue #(.WIDTH(RX_W), .DEPTH(DEPTH)) rx_q_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush_q),
    .push_i  (rx_push),
    .data_i  (rx_char_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .cnt_o   (rx_cnt),
    .full_o  (rx_full_o),
    .empty_o (rx_empty)
  );

  uart_fifo_rx_timer #(.TOUT_W(TOUT_W)) rx_tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arrive_i  (rx_push),
    .empty_i   (rx_empty),
    .tick_i    (char_tick_i),
    .limit_i   (tout_q),
    .timeout_o (rx_timeout_o)
  );

  assign tx_valid_o  = en_q && !tx_empty_o;
  assign tx_aempty_o = (tx_cnt <= CNT_W'(AEMPTY_LVL));
  assign rx_afull_o  = (rx_cnt >= CNT_W'(AFULL_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovf_q <= 1'b0;
      tx_udr_q <= 1'b0;
      rx_ovr_q <= 1'b0;
    end else begin
      tx_ovf_q <= tx_push && tx_full;
      tx_udr_q <= en_q && tx_ready_i && tx_empty_o;
      rx_ovr_q <= rx_push && rx_full_o;
    end
  end

  assign tx_overflow_o = tx_ovf_q;
  assign tx_underrun_o = tx_udr_q;
  assign rx_overrun_o  = rx_ovr_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_addr_e'(bus_addr_i))
      ADDR_RX:   if (en_q && !rx_empty) bus_rdata_o[RX_W-1:0] = rx_head;
      ADDR_CTRL: begin
        bus_rdata_o[CTRL_EN]               = en_q;
        bus_rdata_o[CTRL_TXRST]            = tx_flush_q;
        bus_rdata_o[CTRL_RXRST]            = rx_flush_q;
        bus_rdata_o[CTRL_TOUT +: TOUT_W]   = tout_q;
      end
      ADDR_IDX: begin
        bus_rdata_o[CNT_W-1:0]             = tx_cnt;
        bus_rdata_o[RX_IDX_LSB +: CNT_W]   = rx_cnt;
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             tx_flush_q,
  input logic             rx_flush_q,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic             tx_empty_o,
  input logic             tx_underrun_o,
  input logic             rx_valid_i,
  input logic             rx_full_o,
  input logic             rx_overrun_o,
  input logic             rx_timeout_o,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  logic rx_read;
  assign rx_read = bus_req_i && !bus_we_i && (bus_addr_i == 2'd1);

  a_r4_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CNT_W'(DEPTH));

  a_r5_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CNT_W'(DEPTH));

  a_r5_overrun_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && rx_valid_i && rx_full_o) |=> rx_overrun_o);

  a_r5_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && rx_valid_i && rx_full_o && !rx_read && !rx_flush_q) |=> (rx_cnt == CNT_W'(DEPTH)));

  a_r6_off_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !tx_valid_o);

  a_r7_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_q |=> (tx_cnt == '0));

  a_r7_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_q |=> (rx_cnt == '0));

  a_r8_empty_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> !tx_valid_o);

  a_r9_underrun_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tx_ready_i && tx_empty_o) |=> tx_underrun_o);

  a_r10_timeout_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_timeout_o |-> (rx_cnt != '0));
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_q          (en_q),
  .tx_flush_q    (tx_flush_q),
  .rx_flush_q    (rx_flush_q),
  .bus_req_i     (bus_req_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .tx_ready_i    (tx_ready_i),
  .tx_valid_o    (tx_valid_o),
  .tx_empty_o    (tx_empty_o),
  .tx_underrun_o (tx_underrun_o),
  .rx_valid_i    (rx_valid_i),
  .rx_full_o     (rx_full_o),
  .rx_overrun_o  (rx_overrun_o),
  .rx_timeout_o  (rx_timeout_o),
  .tx_cnt        (tx_cnt),
  .rx_cnt        (rx_cnt)
);

// File: tb/uart_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [9:0]  rx_char = '0;
  logic        rx_valid = 1'b0, char_tick = 1'b0;
  logic        tx_empty, tx_aempty, rx_afull, rx_full;
  logic        tx_ovf, tx_udr, rx_ovr, rx_tout;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_char_i(rx_char), .rx_valid_i(rx_valid), .char_tick_i(char_tick),
    .tx_empty_o(tx_empty), .tx_aempty_o(tx_aempty),
    .rx_afull_o(rx_afull), .rx_full_o(rx_full),
    .tx_overflow_o(tx_ovf), .tx_underrun_o(tx_udr),
    .rx_overrun_o(rx_ovr), .rx_timeout_o(rx_tout)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic rx_send(input logic [9:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(2'd3, d);  check("R1", "index after reset", d, 0);
    bus_read(2'd2, d);  check("R1", "control after reset", d, 0);
    check("R1", "tx_valid", tx_valid, 0);
    check("R1", "flags empty/aempty/afull/full", {tx_empty, tx_aempty, rx_afull, rx_full}, 4'b1100);
    check("R1", "pulses and timeout", {tx_ovf, tx_udr, rx_ovr, rx_tout}, 0);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    bus_write(2'd0, 16'h00AA);
    rx_send(10'h155);
    bus_read(2'd3, d);  check("R6", "index while disabled", d, 0);
    check("R6", "tx_valid while disabled", tx_valid, 0);
    check("R6", "no overrun pulse while disabled", rx_ovr, 0);
    bus_write(2'd2, 16'h0001);
    rx_send(10'h0C3);
    bus_write(2'd2, 16'h0000);
    bus_read(2'd1, d);  check("R6", "rx read while disabled", d, 0);
    bus_read(2'd3, d);  check("R6", "rx kept while disabled", d >> 8, 1);
    bus_write(2'd2, 16'h0001);
    bus_read(2'd1, d);  check("R3", "rx entry after re-enable", d, 16'h00C3);
  endtask

  task automatic t_tx_order();
    logic [15:0] d;
    tx_ready = 1'b0;
    for (int i = 0; i < 16; i++) bus_write(2'd0, 16'(i * 7 + 3));
    bus_read(2'd3, d);  check("R8", "tx count full", d & 16'h1F, 16);
    check("R8", "tx_aempty at 16", tx_aempty, 0);
    bus_write(2'd0, 16'h00EE);
    check("R4", "tx_overflow pulse", tx_ovf, 1);
    bus_read(2'd3, d);  check("R4", "tx count after overflow", d & 16'h1F, 16);
    check("R4", "tx_overflow single cycle", tx_ovf, 0);
    tx_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin
      check("R2", "tx_valid during drain", tx_valid, 1);
      check("R2", "tx byte order", tx_data, (k * 7 + 3) & 8'hFF);
      check("R8", "tx_aempty level", tx_aempty, ((16 - k) <= 4) ? 1 : 0);
      @(negedge clk);
    end
    check("R8", "tx_empty after drain", tx_empty, 1);
    check("R9", "no underrun yet", tx_udr, 0);
    @(negedge clk);
    check("R9", "tx_underrun pulse", tx_udr, 1);
    tx_ready = 1'b0;
    @(negedge clk);
    check("R9", "tx_underrun clears", tx_udr, 0);
  endtask

  task automatic t_rx_flags();
    logic [15:0] d;
    rx_send(10'h055); rx_send(10'h1A3); rx_send(10'h2FF);
    bus_read(2'd3, d);  check("R8", "rx count 3", (d >> 8) & 16'h1F, 3);
    bus_read(2'd1, d);  check("R3", "rx entry plain", d, 16'h0055);
    bus_read(2'd1, d);  check("R3", "rx entry parity flag", d, 16'h01A3);
    bus_read(2'd1, d);  check("R3", "rx entry framing flag", d, 16'h02FF);
    bus_read(2'd1, d);  check("R3", "rx read when empty", d, 0);
    bus_read(2'd3, d);  check("R3", "rx count stays 0", d, 0);
  endtask

  task automatic t_rx_full();
    logic [15:0] d;
    for (int i = 0; i < 16; i++) begin
      rx_send(10'(i * 37 + 5));
      check("R8", "rx_afull level", rx_afull, ((i + 1) >= 12) ? 1 : 0);
    end
    check("R8", "rx_full at 16", rx_full, 1);
    rx_send(10'h3FF);
    check("R5", "rx_overrun pulse", rx_ovr, 1);
    bus_read(2'd3, d);  check("R5", "rx count after overrun", (d >> 8) & 16'h1F, 16);
    for (int i = 0; i < 16; i++) begin
      bus_read(2'd1, d);  check("R5", "rx entry kept", d, (i * 37 + 5) & 10'h3FF);
    end
    check("R8", "rx_full cleared", rx_full, 0);
  endtask

  task automatic t_flush();
    logic [15:0] d;
    for (int i = 0; i < 3; i++) bus_write(2'd0, 16'h0011);
    rx_send(10'h001); rx_send(10'h002);
    bus_write(2'd2, 16'h0005);
    bus_read(2'd2, d);  check("R7", "tx reset bit reads 1", d, 16'h0005);
    bus_read(2'd2, d);  check("R7", "tx reset bit cleared", d, 16'h0001);
    bus_read(2'd3, d);  check("R7", "tx flushed, rx kept", d, 16'h0200);
    bus_write(2'd0, 16'h0022);
    bus_write(2'd2, 16'h0009);
    bus_read(2'd2, d);  check("R7", "rx reset bit reads 1", d, 16'h0009);
    bus_read(2'd3, d);  check("R7", "rx flushed, tx kept", d, 16'h0001);
    bus_write(2'd2, 16'h0005);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    bus_write(2'd2, 16'h0031);
    for (int i = 0; i < 5; i++) tick();
    check("R10", "no timeout when empty", rx_tout, 0);
    rx_send(10'h010);
    tick(); tick();
    check("R10", "no timeout after 2 ticks", rx_tout, 0);
    tick();
    check("R10", "timeout after 3 ticks", rx_tout, 1);
    rx_send(10'h011);
    check("R10", "arrival clears timeout", rx_tout, 0);
    tick(); tick(); tick();
    check("R10", "timeout again", rx_tout, 1);
    bus_read(2'd1, d); bus_read(2'd1, d);
    check("R10", "empty clears timeout", rx_tout, 0);
    bus_write(2'd2, 16'h0001);
    rx_send(10'h012);
    for (int i = 0; i < 20; i++) tick();
    check("R10", "limit 0 disables", rx_tout, 0);
    bus_read(2'd1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_tx_order();
    t_rx_flags();
    t_rx_full();
    t_flush();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule